// File: doc/BRIEF.md
# Shift-Add Perceptron Neuron

This block is a sequential perceptron datapath that works without a multiplier. Every input and every weight arrives already converted to a base-two logarithm. The block multiplies them by adding the two logarithm codes and passing the sum through an antilog shifter. It then adds the signed product into a wide dot-product register. One input/weight pair is taken per clock while `in_valid` is high.

When a pair is flagged as the last of a neuron, the completed sum goes through three stages in order. First comes a power-of-two scale, which is a plain left shift. Next is a sigmoid-like activation built only from shifts and subtractions. Last, a leading-one log converter turns the result back into a logarithm code. The output therefore uses the same sign-magnitude log format as the inputs, and another neuron can consume it directly.

The block is meant to be shared over time by an outside sequencer. That sequencer streams a neuron's pairs, asserts the last strobe on the final pair, and collects one logarithmic output per neuron.

Top module: `shadd_perceptron`

## Requirements
- R1: A synchronous active-high `rst` sets `out_valid` to 0 and `out_data` to 0 and discards any partial sum. The first sum after reset contains only the pairs accepted after reset.
- R2: Each 16-bit operand is sign-magnitude: bit 15 is the sign, bits 14:11 are the integer part of the log code and bits 10:0 its fraction. Write s for the 16-bit sum of the two 15-bit codes, with integer part ip = s[15:11] and fraction f = s[10:0]. The product magnitude is floor((2048+f)·2^ip / 2^26) in units of 2^-15, limited to 32767. The product sign is the XOR of the two operand signs.
- R3: Products are summed into a 24-bit two's-complement accumulator that saturates at +8388607 and −8388607.
- R4: The first accepted pair after an output (or after reset) starts a new sum. Back-to-back last pairs each yield a sum of exactly one product.
- R5: `out_valid` is high for exactly one cycle, the cycle after a clock edge that accepts a pair with `in_last` high. `out_data` changes only at such an edge and holds its value otherwise.
- R6: At the last pair, the absolute value of the final sum is shifted left by `scale_sh` (0..7). The result is limited to 524287, which is just under 16 in units of 2^-15.
- R7: Take the scaled magnitude m and split it into n = m[18:15] and g = m[14:0]. The activation magnitude is a = 32768 − ((32768 − floor(g/2)) >> n), limited to 32767. The activation takes the sign of the final sum.
- R8: `out_data` bit 15 is the sign of the final sum. Bits 14:11 give the bit position p of the leading one of a. Bits 10:0 are the 11 bits below that leading one, left-aligned and zero-padded, equal to floor((a−2^p)·2^11 / 2^p). When a is 0, bits 14:0 are 0.
- R9: Cycles with `in_valid` low leave the sum and the output unchanged, whatever `in_x`, `in_w`, `in_last` and `scale_sh` carry.
- R10: `scale_sh` is sampled only in the cycle of the last pair. Its values during earlier pairs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A pair is present this cycle |
| in_last | input | 1 | The pair is the last of the current neuron |
| in_x | input | 16 | Input operand, sign-magnitude log code |
| in_w | input | 16 | Weight operand, sign-magnitude log code |
| scale_sh | input | 3 | Left-shift amount applied to the final sum |
| out_valid | output | 1 | One-cycle strobe for a new result |
| out_data | output | 16 | Activated neuron output, sign-magnitude log code |

## Verification
The bench uses the package defaults: 15-bit magnitudes, a 4-bit integer and 11-bit fraction in each log code, a 24-bit accumulator and a 3-bit scale shift. With these widths a few hundred maximum-size products are enough to push the accumulator into saturation. A long run of negative products then brings the sum back below the scale-stage limit, which makes a wrapping accumulator produce a visibly different output code. The 3-bit shift reaches a scaled magnitude of 16 and above, which exercises both the scale-stage limit and the top-end clamp of the activation. Small log codes reach the antilog underflow to zero.

// File: rtl/shadd_pkg.sv
package shadd_pkg;
    localparam int MAG_W    = 15;
    localparam int LINT_W   = 4;
    localparam int LFRAC_W  = 11;
    localparam int ACC_W    = 24;
    localparam int SCL_W    = 3;
    localparam int SV_INT_W = 4;

    localparam int CODE_W = LINT_W + LFRAC_W;
    localparam int LSUM_W = CODE_W + 1;
    localparam int WORD_W = MAG_W + 1;
    localparam int SV_W   = SV_INT_W + MAG_W;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic                    fresh;
        logic                    ovld;
        logic [WORD_W-1:0]       odata;
    } pe_state_t;
endpackage

// File: rtl/shadd_antilog.sv
module shadd_antilog
    import shadd_pkg::*;
(
    input  logic [LSUM_W-1:0] lsum,
    output logic [MAG_W-1:0]  mag
);
    localparam int IP_W    = LSUM_W - LFRAC_W;
    localparam int DROP    = LFRAC_W + MAG_W;
    localparam int WIDE_W  = LFRAC_W + 1 + (1 << IP_W);
    localparam int ZERO_IP = DROP - (LFRAC_W + 1);

    logic [IP_W-1:0]   ip;
    logic [WIDE_W-1:0] mant_w;
    logic [WIDE_W-1:0] shifted_w;
    logic [WIDE_W-1:0] scaled_w;

    always_comb begin
        ip        = lsum[LSUM_W-1:LFRAC_W];
        mant_w    = WIDE_W'({1'b1, lsum[LFRAC_W-1:0]});
        shifted_w = mant_w << ip;
        scaled_w  = shifted_w >> DROP;
        if (|scaled_w[WIDE_W-1:MAG_W]) begin
            mag = {MAG_W{1'b1}};
        end else begin
            mag = scaled_w[MAG_W-1:0];
        end
    end

    always_comb begin
        if (!$isunknown(lsum)) begin
            AST_UNDERFLOW_ZERO: assert (int'(ip) > ZERO_IP || mag == '0); // R2
        end
    end
endmodule

// File: rtl/shadd_activation.sv
module shadd_activation
    import shadd_pkg::*;
(
    input  logic [SV_W-1:0]  sv_mag,
    output logic [MAG_W-1:0] act_mag
);
    localparam logic [MAG_W:0] ONE = (MAG_W+1)'(1) << MAG_W;

    logic [SV_INT_W-1:0] n;
    logic [MAG_W-1:0]    g;
    logic [MAG_W:0]      tail_d;
    logic [MAG_W:0]      shr_d;
    logic [MAG_W:0]      raw_d;

    always_comb begin
        n      = sv_mag[SV_W-1:MAG_W];
        g      = sv_mag[MAG_W-1:0];
        tail_d = ONE - (MAG_W+1)'(g >> 1);
        shr_d  = tail_d >> n;
        raw_d  = ONE - shr_d;
        if (raw_d[MAG_W]) begin
            act_mag = {MAG_W{1'b1}};
        end else begin
            act_mag = raw_d[MAG_W-1:0];
        end
    end

    always_comb begin
        if (!$isunknown(sv_mag)) begin
            AST_ACT_ZERO_AT_ORIGIN: assert (sv_mag != '0 || act_mag == '0); // R7
        end
    end
endmodule

// File: rtl/shadd_log2.sv
module shadd_log2
    import shadd_pkg::*;
(
    input  logic [MAG_W-1:0]  mag,
    output logic [CODE_W-1:0] code
);
    logic [LINT_W-1:0] pos;
    logic              found;
    logic [MAG_W-1:0]  norm;

    always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int i = 0; i < MAG_W; i++) begin
            if (mag[i]) begin
                pos   = LINT_W'(i);
                found = 1'b1;
            end
        end
        norm = mag << (LINT_W'(MAG_W - 1) - pos);
        if (found) begin
            code = {pos, norm[MAG_W-2 -: LFRAC_W]};
        end else begin
            code = '0;
        end
    end

    always_comb begin
        if (!$isunknown(mag)) begin
            AST_LOG_ZERO: assert (mag != '0 || code == '0); // R8
            AST_LOG_RANGE: assert (mag == '0 ||
                ((mag >> code[CODE_W-1:LFRAC_W]) == MAG_W'(1))); // R8
        end
    end
endmodule

// File: rtl/shadd_perceptron.sv
module shadd_perceptron
    import shadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [WORD_W-1:0] in_x,
    input  logic [WORD_W-1:0] in_w,
    input  logic [SCL_W-1:0]  scale_sh,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);
    localparam int SHW_W = ACC_W - 1 + (1 << SCL_W) - 1;
    localparam logic signed [ACC_W:0] ACC_HI =
        $signed((ACC_W+1)'((1 << (ACC_W - 1)) - 1));
    localparam logic signed [ACC_W:0] ACC_LO = -ACC_HI;

    pe_state_t q, d;

    logic                    prod_sign;
    logic [LSUM_W-1:0]       lsum;
    logic [MAG_W-1:0]        prod_mag;
    logic signed [ACC_W:0]   prod_w;
    logic signed [ACC_W:0]   base_w;
    logic signed [ACC_W:0]   sum_w;
    logic signed [ACC_W-1:0] acc_new;
    logic                    fin_neg;
    logic [ACC_W-1:0]        abs_v;
    logic [SHW_W-1:0]        scaled_v;
    logic [SV_W-1:0]         sv_mag;
    logic [MAG_W-1:0]        act_mag;
    logic [CODE_W-1:0]       out_code;

    assign prod_sign = in_x[WORD_W-1] ^ in_w[WORD_W-1];
    assign lsum      = LSUM_W'(in_x[CODE_W-1:0]) + LSUM_W'(in_w[CODE_W-1:0]);

    shadd_antilog u_antilog (
        .lsum (lsum),
        .mag  (prod_mag)
    );

    shadd_activation u_act (
        .sv_mag  (sv_mag),
        .act_mag (act_mag)
    );

    shadd_log2 u_log (
        .mag  (act_mag),
        .code (out_code)
    );

    always_comb begin
        prod_w = $signed({{(ACC_W + 1 - MAG_W){1'b0}}, prod_mag});
        if (prod_sign) begin
            prod_w = -prod_w;
        end
        base_w = q.fresh ? '0 : {q.acc[ACC_W-1], q.acc};
        sum_w  = base_w + prod_w;
        if (sum_w > ACC_HI) begin
            acc_new = ACC_HI[ACC_W-1:0];
        end else if (sum_w < ACC_LO) begin
            acc_new = ACC_LO[ACC_W-1:0];
        end else begin
            acc_new = sum_w[ACC_W-1:0];
        end

        fin_neg  = acc_new[ACC_W-1];
        abs_v    = fin_neg ? -acc_new : acc_new;
        scaled_v = SHW_W'(abs_v[ACC_W-2:0]) << scale_sh;
        if (|scaled_v[SHW_W-1:SV_W]) begin
            sv_mag = {SV_W{1'b1}};
        end else begin
            sv_mag = scaled_v[SV_W-1:0];
        end

        d      = q;
        d.ovld = 1'b0;
        if (in_valid) begin
            d.acc   = acc_new;
            d.fresh = in_last;
            if (in_last) begin
                d.ovld  = 1'b1;
                d.odata = {fin_neg, out_code};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{acc: '0, fresh: 1'b1, ovld: 1'b0, odata: '0};
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.ovld;
    assign out_data  = q.odata;

    AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> out_valid); // R5
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_last) |=> !out_valid); // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_last) |=> $stable(out_data)); // R5
    AST_IDLE_KEEPS_SUM: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(q.acc)); // R9
    AST_ACC_NO_MIN: assert property (@(posedge clk) disable iff (rst)
        q.acc != {1'b1, {(ACC_W - 1){1'b0}}}); // R3
endmodule

// File: tb/shadd_perceptron_bench.sv
module shadd_perceptron_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic [15:0] in_x = '0;
    logic [15:0] in_w = '0;
    logic [2:0]  scale_sh = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;
    longint macc = 0;
    bit mfresh = 1;
    logic [15:0] last_out = '0;

    always #4 clk = ~clk;

    shadd_perceptron u_shadd_perceptron (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
        .in_x(in_x), .in_w(in_w), .scale_sh(scale_sh),
        .out_valid(out_valid), .out_data(out_data)
    );

    // {valid, last, scale[2:0], x[15:0], w[15:0]}
    localparam int NV = 12;
    localparam logic [36:0] VECS [0:NV-1] = '{
        {1'b1, 1'b0, 3'd0, 16'h7000, 16'h7000},
        {1'b1, 1'b0, 3'd0, 16'h6800, 16'h7123},
        {1'b1, 1'b1, 3'd2, 16'hF000, 16'h5ABC},
        {1'b1, 1'b1, 3'd0, 16'h7FFF, 16'h7000},
        {1'b1, 1'b0, 3'd0, 16'h73FF, 16'hF3FF},
        {1'b0, 1'b1, 3'd7, 16'h7FFF, 16'h7FFF},
        {1'b1, 1'b1, 3'd5, 16'h0401, 16'h8402},
        {1'b1, 1'b0, 3'd0, 16'h7700, 16'h6E55},
        {1'b1, 1'b0, 3'd0, 16'h7700, 16'h6E55},
        {1'b1, 1'b1, 3'd7, 16'h7300, 16'h7300},
        {1'b1, 1'b0, 3'd0, 16'hF7FF, 16'h7700},
        {1'b1, 1'b1, 3'd1, 16'h5000, 16'h6000}
    };

    function automatic longint m_prod(logic [15:0] x, logic [15:0] w);
        longint s, ip, f, p;
        s  = longint'(x[14:0]) + longint'(w[14:0]);
        ip = s >> 11;
        f  = s & 2047;
        p  = ((2048 + f) << ip) >> 26;
        if (p > 32767) p = 32767;
        return (x[15] ^ w[15]) ? -p : p;
    endfunction

    function automatic logic [15:0] m_out(longint acc, int scl);
        logic   s;
        longint m, n, g, tail, a, p, fr, c;
        s = (acc < 0);
        m = s ? -acc : acc;
        m = m << scl;
        if (m > 524287) m = 524287;
        n = m >> 15;
        g = m & 32767;
        tail = 32768 - (g >> 1);
        a = 32768 - (tail >> n);
        if (a > 32767) a = 32767;
        if (a == 0) begin
            c = 0;
        end else begin
            p = 14;
            while (((a >> p) & 1) == 0) p--;
            fr = ((a - (longint'(1) << p)) << 11) >> p;
            c = p * 2048 + fr;
        end
        return {s, c[14:0]};
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, move to the next falling edge, update the model.
    task automatic step(bit v, bit l, logic [2:0] scl, logic [15:0] x, logic [15:0] w);
        longint exp_acc;
        in_valid = v; in_last = l; scale_sh = scl; in_x = x; in_w = w;
        @(negedge clk);
        if (v) begin
            exp_acc = mfresh ? 0 : macc;
            exp_acc += m_prod(x, w);
            if (exp_acc > 8388607) exp_acc = 8388607;
            if (exp_acc < -8388607) exp_acc = -8388607;
            macc = exp_acc;
            mfresh = l;
            if (l) last_out = m_out(macc, int'(scl));
        end
    endtask

    task automatic step_chk(string req, bit v, bit l, logic [2:0] scl,
                            logic [15:0] x, logic [15:0] w);
        step(v, l, scl, x, w);
        chk({req, " valid"}, {15'd0, out_valid}, {15'd0, (v && l)});
        chk({req, " data"}, out_data, last_out);
    endtask

    task automatic idle();
        in_valid = 0; in_last = 0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1 reset valid", {15'd0, out_valid}, 16'd0);
        chk("R1 reset data", out_data, 16'h0000);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            step_chk("R2/R8 table", VECS[i][36], VECS[i][35], VECS[i][34:32],
                     VECS[i][31:16], VECS[i][15:0]);
        end
        idle();

        // R2 R7 R8: 0.5*0.5 = 0.25 -> activation 4096 -> code 0x6000
        step(1, 1, 3'd0, 16'h7000, 16'h7000);
        chk("R2 R7 R8 quarter", out_data, 16'h6000);
        idle();
        chk("R5 single pulse", {15'd0, out_valid}, 16'd0);
        chk("R5 hold", out_data, 16'h6000);

        // R6: shift by 3 -> 2.0 -> code 0x7400
        step(1, 1, 3'd3, 16'h7000, 16'h7000);
        chk("R6 scale", out_data, 16'h7400);

        // R2 sign: negative operand
        step(1, 1, 3'd0, 16'hF000, 16'h7000);
        chk("R2 sign xor", out_data, 16'hE000);

        // R2 R8: underflowing product gives zero output
        step(1, 1, 3'd0, 16'h0000, 16'h0000);
        chk("R2 R8 zero", out_data, 16'h0000);

        // R9: idle cycles with junk are ignored
        step(1, 0, 3'd0, 16'h7000, 16'h7000);
        for (int k = 0; k < 3; k++) begin
            in_valid = 0; in_last = 1; in_x = 16'h7FFF; in_w = 16'h7FFF; scale_sh = 3'd7;
            @(negedge clk);
            chk("R9 idle no valid", {15'd0, out_valid}, 16'd0);
            chk("R9 idle output unchanged", out_data, 16'h0000);
        end
        step(1, 1, 3'd0, 16'h0000, 16'h0000);
        chk("R9 idle ignored in sum", out_data, 16'h6000);

        // R10: scale changes before the last pair have no effect
        step(1, 0, 3'd7, 16'h7000, 16'h7000);
        step(1, 0, 3'd7, 16'h0000, 16'h0000);
        step(1, 1, 3'd0, 16'h0000, 16'h0000);
        chk("R10 scale sampled at last", out_data, 16'h6000);

        // R4: back-to-back last pairs
        step(1, 1, 3'd0, 16'h7000, 16'h7000);
        chk("R4 first of pair", out_data, 16'h6000);
        step(1, 1, 3'd3, 16'h7000, 16'h7000);
        chk("R4 second restarts", out_data, 16'h7400);
        chk("R4 valid stays", {15'd0, out_valid}, 16'd1);

        // R3: saturate high, then come back down
        for (int k = 0; k < 300; k++) step(1, 0, 3'd0, 16'h7FFF, 16'h7FFF);
        for (int k = 0; k < 249; k++) step(1, 0, 3'd0, 16'hFFFF, 16'h7FFF);
        step(1, 1, 3'd0, 16'hFFFF, 16'h7FFF);
        chk("R3 accumulator saturation", out_data, 16'h77C0);
        chk("R3 model agree", out_data, last_out);

        // R6 R7: scale-stage limit and activation clamp, negative sign
        for (int k = 0; k < 40; k++) step(1, 0, 3'd0, 16'hFFFF, 16'h7FFF);
        step(1, 1, 3'd7, 16'hFFFF, 16'h7FFF);
        chk("R6 R7 clamp negative", out_data, 16'hF7FF);

        // R1: reset in the middle of a sum
        for (int k = 0; k < 5; k++) step(1, 0, 3'd0, 16'h7FFF, 16'h7800);
        rst = 1;
        @(negedge clk);
        rst = 0;
        macc = 0; mfresh = 1;
        chk("R1 mid reset data", out_data, 16'h0000);
        chk("R1 mid reset valid", {15'd0, out_valid}, 16'd0);
        step(1, 1, 3'd0, 16'h7000, 16'h7000);
        chk("R1 sum cleared by reset", out_data, 16'h6000);
        idle();
        finish_run();
    end
endmodule